// File: doc/BRIEF.md
# Hibernate and wake-up sequencer

This block controls the system power enable and the system reset from the always-on slow clock domain. Software asks for hibernation through a register write. The block then drops the power enable and waits for a wake-up. A wake-up comes either from an external active-low pin, which must stay asserted continuously for a programmable number of slow-clock ticks, or from an alarm request. After a wake-up the block turns power back on and holds the system reset low for a programmable number of ticks. It then returns to normal operation.

The block has three states. RUN has power on and reset released. HIBERNATE has power off and reset held low. POWER_UP has power on and reset held low. The transitions are:
- HIB_ENTER, from RUN to HIBERNATE, on an accepted hibernate request.
- WAKE, from HIBERNATE to POWER_UP, when the pin filter completes or an alarm request is seen.
- RELEASE, from POWER_UP to RUN, when the reset-hold count expires.

Register writes are guarded by a key. A key write arms exactly one following write to a control register. The `tick` input marks one slow-clock period. Both counters advance only on cycles where it is high.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset the block is in RUN with `pwr_en`=1 and `sys_rst_n`=1. Both limits are zero and the write guard is disarmed.
- R2: A write to offset 0x3C with `wr_data[15:0]`=0xA55A arms the guard. A key write with any other data disarms it. A write to offset 0x20, 0x24 or 0x28 takes effect only while the guard is armed, and it always disarms the guard. Writes to other offsets leave the guard unchanged.
- R3: An accepted write to offset 0x20 with bit 0 = 1, made in RUN, enters HIBERNATE (`pwr_en`=0, `sys_rst_n`=0). The same write with bit 0 = 0 has no effect.
- R4: Offset 0x24 holds the wake filter limit in bits 15:5, and bits 4:0 of the limit read as zero. The stored limit in ticks is `wr_data & 0xFFE0`. Any value of 0xFFE0 or more saturates to 0xFFE0.
- R5: In HIBERNATE, a wake pin held low for the full filter limit causes WAKE. The pin passes through a 2-stage synchronizer. With a tick on every cycle, `pwr_en` rises exactly limit+3 cycles after the pin falls. A release before the limit is reached restarts the count from zero.
- R6: In HIBERNATE, `alarm_wake`=1 on a clock edge causes WAKE on that edge, whatever the pin filter holds. In RUN and POWER_UP, `alarm_wake` has no effect.
- R7: POWER_UP drives `pwr_en`=1 and `sys_rst_n`=0. RELEASE occurs on the edge after the reset-hold limit in ticks has been counted. With a tick on every cycle, `sys_rst_n` stays low for limit+1 cycles after `pwr_en` rises.
- R8: Offset 0x28 holds the reset-hold limit in bits 11:5, with bits 4:0 zero. The stored limit is `wr_data & 0xFE0`, and any value of 0xFE0 or more saturates to 0xFE0.
- R9: A hibernate request made in HIBERNATE or POWER_UP is ignored. Power can only fall from RUN.
- R10: Both the filter count and the reset-hold count advance only on cycles with `tick`=1.
- R11: The wake pin has no effect outside HIBERNATE. Filtering starts afresh on entry to HIBERNATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | One-cycle slow-clock tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| wake_n | input | 1 | External wake pin, active low, asynchronous |
| alarm_wake | input | 1 | Alarm wake request |
| pwr_en | output | 1 | System power enable |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The wake path is tried with four pin patterns:
- A low pulse shorter than the filter followed by a full-length assertion. The exact wake latency shows whether a release really restarts the count.
- The pin already low when hibernation begins. This shows that the count starts at entry and not during RUN.
- An alarm pulse in RUN and in HIBERNATE. This separates the two wake sources.
- A saturating filter value, to show the field cap.

The reset-hold duration is measured as follows:
- Exactly, with a tick on every cycle, using a masked value and a saturating value.
- With a tick on every fourth cycle, to tell tick counting apart from cycle counting.

Unarmed, wrongly keyed and bit-0-clear writes, and a hibernate request during POWER_UP, must all leave power untouched.

// File: rtl/hws_pkg.sv
package hws_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HIB   = 2'd1,
        ST_PWRUP = 2'd2
    } hws_state_e;

    localparam logic [7:0]  OFS_HIB_DEF  = 8'h20;
    localparam logic [7:0]  OFS_FILT_DEF = 8'h24;
    localparam logic [7:0]  OFS_HOLD_DEF = 8'h28;
    localparam logic [7:0]  OFS_KEY_DEF  = 8'h3C;
    localparam logic [15:0] KEY_DEF      = 16'hA55A;

endpackage

// File: rtl/hws_regs.sv
module hws_regs #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter int          FLD_LSB  = 5,
    parameter int          FILT_MSB = 15,
    parameter int          HOLD_MSB = 11,
    parameter int          KEY_W    = 16,
    parameter logic [ADDR_W-1:0] OFS_HIB  = 8'h20,
    parameter logic [ADDR_W-1:0] OFS_FILT = 8'h24,
    parameter logic [ADDR_W-1:0] OFS_HOLD = 8'h28,
    parameter logic [ADDR_W-1:0] OFS_KEY  = 8'h3C,
    parameter logic [KEY_W-1:0]  KEY      = 16'hA55A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                hib_go,
    output logic [FILT_MSB:0]   filt_limit,
    output logic [HOLD_MSB:0]   hold_limit
);

    localparam int FILT_FW = FILT_MSB - FLD_LSB + 1;
    localparam int HOLD_FW = HOLD_MSB - FLD_LSB + 1;
    localparam logic [DATA_W-1:0] FILT_CAP =
        DATA_W'({FILT_FW{1'b1}}) << FLD_LSB;
    localparam logic [DATA_W-1:0] HOLD_CAP =
        DATA_W'({HOLD_FW{1'b1}}) << FLD_LSB;

    logic               armed_q;
    logic [FILT_FW-1:0] filt_q;
    logic [HOLD_FW-1:0] hold_q;
    logic               sel_hib, sel_filt, sel_hold, sel_key;
    logic               ctl_wr;

    always_comb begin
        sel_hib  = wr_en && (wr_addr == OFS_HIB);
        sel_filt = wr_en && (wr_addr == OFS_FILT);
        sel_hold = wr_en && (wr_addr == OFS_HOLD);
        sel_key  = wr_en && (wr_addr == OFS_KEY);
        ctl_wr   = sel_hib || sel_filt || sel_hold;
        hib_go   = sel_hib && armed_q && wr_data[0];
    end

    // write guard: one key write arms exactly one control write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (sel_key) begin
            armed_q <= (wr_data[KEY_W-1:0] == KEY);
        end else if (ctl_wr) begin
            armed_q <= 1'b0;
        end
    end

    // saturating field capture, low bits dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= '0;
            hold_q <= '0;
        end else begin
            if (sel_filt && armed_q) begin
                filt_q <= (wr_data >= FILT_CAP) ? {FILT_FW{1'b1}}
                                                : wr_data[FILT_MSB:FLD_LSB];
            end
            if (sel_hold && armed_q) begin
                hold_q <= (wr_data >= HOLD_CAP) ? {HOLD_FW{1'b1}}
                                                : wr_data[HOLD_MSB:FLD_LSB];
            end
        end
    end

    assign filt_limit = {filt_q, {FLD_LSB{1'b0}}};
    assign hold_limit = {hold_q, {FLD_LSB{1'b0}}};

endmodule

// File: rtl/hws_sync.sv
module hws_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/hws_tick_count.sv
module hws_tick_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);

    logic [W-1:0] cnt_q;

    assign done = (cnt_q >= limit);

    // stops at the limit, so it can never wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq
    import hws_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int FLD_LSB     = 5,
    parameter int FILT_MSB    = 15,
    parameter int HOLD_MSB    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake_n,
    input  logic              alarm_wake,
    output logic              pwr_en,
    output logic              sys_rst_n
);

    localparam int FILT_CNT_W = FILT_MSB + 1;
    localparam int HOLD_CNT_W = HOLD_MSB + 1;

    hws_state_e            state_q, state_d;
    logic                  hib_go;
    logic [FILT_CNT_W-1:0] filt_limit;
    logic [HOLD_CNT_W-1:0] hold_limit;
    logic                  wake_sync_n;
    logic                  wake_act;
    logic                  filt_done, hold_done;
    logic                  filt_clr, hold_clr;

    hws_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .FLD_LSB  (FLD_LSB),
        .FILT_MSB (FILT_MSB),
        .HOLD_MSB (HOLD_MSB),
        .KEY_W    (16),
        .OFS_HIB  (ADDR_W'(OFS_HIB_DEF)),
        .OFS_FILT (ADDR_W'(OFS_FILT_DEF)),
        .OFS_HOLD (ADDR_W'(OFS_HOLD_DEF)),
        .OFS_KEY  (ADDR_W'(OFS_KEY_DEF)),
        .KEY      (KEY_DEF)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .hib_go     (hib_go),
        .filt_limit (filt_limit),
        .hold_limit (hold_limit)
    );

    hws_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (wake_n),
        .dout  (wake_sync_n)
    );

    assign wake_act = !wake_sync_n;
    assign filt_clr = (state_q != ST_HIB) || !wake_act;
    assign hold_clr = (state_q != ST_PWRUP);

    hws_tick_count #(.W(FILT_CNT_W)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (filt_clr),
        .tick  (tick),
        .limit (filt_limit),
        .done  (filt_done)
    );

    hws_tick_count #(.W(HOLD_CNT_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hold_clr),
        .tick  (tick),
        .limit (hold_limit),
        .done  (hold_done)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (hib_go) state_d = ST_HIB;
            ST_HIB:   if (alarm_wake || (wake_act && filt_done)) state_d = ST_PWRUP;
            ST_PWRUP: if (hold_done) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs decoded from the current state
    always_comb begin
        pwr_en    = 1'b1;
        sys_rst_n = 1'b1;
        unique case (state_q)
            ST_RUN:   begin pwr_en = 1'b1; sys_rst_n = 1'b1; end
            ST_HIB:   begin pwr_en = 1'b0; sys_rst_n = 1'b0; end
            ST_PWRUP: begin pwr_en = 1'b1; sys_rst_n = 1'b0; end
            default:  begin pwr_en = 1'b1; sys_rst_n = 1'b1; end
        endcase
    end

endmodule

// File: rtl/hws_checker.sv
module hws_checker #(
    parameter int FILT_W = 16,
    parameter int HOLD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wake_act,
    input logic              alarm_wake,
    input logic              pwr_en,
    input logic              sys_rst_n,
    input logic [FILT_W-1:0] filt_limit,
    input logic [HOLD_W-1:0] hold_limit
);

    logic [FILT_W:0] fc_q;
    logic [HOLD_W:0] hc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fc_q <= '0;
        end else if (!wake_act || pwr_en) begin
            fc_q <= '0;
        end else if (tick && !fc_q[FILT_W]) begin
            fc_q <= fc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc_q <= '0;
        end else if (sys_rst_n || !pwr_en) begin
            hc_q <= '0;
        end else if (tick && !hc_q[HOLD_W]) begin
            hc_q <= hc_q + 1'b1;
        end
    end

    AST_PIN_WAKE_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwr_en) && !$past(alarm_wake)) |-> (fc_q >= {1'b0, $past(filt_limit)})); // R5
    AST_HOLD_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (hc_q >= {1'b0, $past(hold_limit)})); // R7
    AST_WAKE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> !sys_rst_n); // R7
    AST_OFF_ONLY_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $past(sys_rst_n)); // R9
    AST_RELEASE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(pwr_en)); // R7

endmodule

bind hib_wake_seq hws_checker #(
    .FILT_W (FILT_CNT_W),
    .HOLD_W (HOLD_CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wake_act   (wake_act),
    .alarm_wake (alarm_wake),
    .pwr_en     (pwr_en),
    .sys_rst_n  (sys_rst_n),
    .filt_limit (filt_limit),
    .hold_limit (hold_limit)
);

// File: tb/hib_wake_seq_test.sv
module hib_wake_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_HIB  = 8'h20;
    localparam logic [7:0] A_FILT = 8'h24;
    localparam logic [7:0] A_HOLD = 8'h28;
    localparam logic [7:0] A_KEY  = 8'h3C;
    localparam int WATCHDOG = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wake_n = 1'b1;
    logic        alarm_wake = 1'b0;
    logic        pwr_en, sys_rst_n;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int div_cnt = 0;
    int cyc = 0;
    bit done = 1'b0;

    hib_wake_seq uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wake_n(wake_n),
        .alarm_wake(alarm_wake), .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        if (div_cnt >= tick_div - 1) begin
            div_cnt = 0;
            tick = 1'b1;
        end else begin
            div_cnt++;
            tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic guarded_wr(input logic [7:0] a, input logic [31:0] d);
        wr(A_KEY, 32'h0000_A55A);
        wr(a, d);
    endtask

    task automatic count_to_pwr(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!pwr_en && k < 70000);
    endtask

    task automatic count_to_release(output int k);
        k = 0;
        while (!sys_rst_n && k < 70000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic alarm_cycle(input string req, output int k);
        guarded_wr(A_HIB, 32'h1);
        check(pwr_en == 1'b0, req, pwr_en, 0);
        alarm_wake = 1'b1;
        @(negedge clk);
        alarm_wake = 1'b0;
        check(pwr_en == 1'b1 && sys_rst_n == 1'b0, req, {pwr_en, sys_rst_n}, 2);
        count_to_release(k);
    endtask

    task automatic t_reset();
        check(pwr_en == 1'b1, "R1", pwr_en, 1);
        check(sys_rst_n == 1'b1, "R1", sys_rst_n, 1);
    endtask

    task automatic t_guard();
        wr(A_HIB, 32'h1);
        repeat (3) @(negedge clk);
        check(pwr_en == 1'b1, "R2 unarmed write", pwr_en, 1);
        wr(A_KEY, 32'h0000_1234);
        wr(A_HIB, 32'h1);
        repeat (3) @(negedge clk);
        check(pwr_en == 1'b1, "R2 wrong key", pwr_en, 1);
        wr(A_KEY, 32'h0000_A55A);
        wr(A_KEY, 32'h0000_5AA5);
        wr(A_HIB, 32'h1);
        repeat (3) @(negedge clk);
        check(pwr_en == 1'b1, "R2 disarm by bad key", pwr_en, 1);
        wr(A_KEY, 32'h0000_A55A);
        wr(8'h10, 32'h0);
        wr(A_HIB, 32'h0);
        repeat (3) @(negedge clk);
        check(pwr_en == 1'b1, "R3 bit0 clear", pwr_en, 1);
        wr(A_HIB, 32'h1);
        repeat (3) @(negedge clk);
        check(pwr_en == 1'b1, "R2 one write per key", pwr_en, 1);
    endtask

    task automatic t_filter();
        int k;
        guarded_wr(A_FILT, 32'h5F);
        guarded_wr(A_HOLD, 32'h40);
        guarded_wr(A_HIB, 32'h1);
        check(pwr_en == 1'b0 && sys_rst_n == 1'b0, "R3", {pwr_en, sys_rst_n}, 0);
        wake_n = 1'b0;
        repeat (30) @(negedge clk);
        wake_n = 1'b1;
        repeat (10) @(negedge clk);
        check(pwr_en == 1'b0, "R5 short pulse", pwr_en, 0);
        wake_n = 1'b0;
        count_to_pwr(k);
        check(k == 64 + 3, "R5 wake latency R4 masked limit", k, 67);
        check(sys_rst_n == 1'b0, "R7 reset low on wake", sys_rst_n, 0);
        wake_n = 1'b1;
        count_to_release(k);
        check(k == 64 + 1, "R7 hold length", k, 65);
    endtask

    task automatic t_alarm();
        int k;
        alarm_wake = 1'b1;
        repeat (3) @(negedge clk);
        alarm_wake = 1'b0;
        check(pwr_en == 1'b1 && sys_rst_n == 1'b1, "R6 alarm in RUN", {pwr_en, sys_rst_n}, 3);
        alarm_cycle("R6", k);
        check(k == 65, "R6 hold after alarm", k, 65);
    endtask

    task automatic t_hib_in_powerup();
        int k;
        guarded_wr(A_HIB, 32'h1);
        alarm_wake = 1'b1;
        @(negedge clk);
        alarm_wake = 1'b0;
        guarded_wr(A_HIB, 32'h1);
        check(pwr_en == 1'b1, "R9 request in POWER_UP", pwr_en, 1);
        count_to_release(k);
        repeat (5) @(negedge clk);
        check(pwr_en == 1'b1 && sys_rst_n == 1'b1, "R9 back in RUN", {pwr_en, sys_rst_n}, 3);
    endtask

    task automatic t_pin_in_run();
        int k;
        wake_n = 1'b0;
        repeat (200) @(negedge clk);
        check(pwr_en == 1'b1 && sys_rst_n == 1'b1, "R11 pin in RUN", {pwr_en, sys_rst_n}, 3);
        guarded_wr(A_HIB, 32'h1);
        check(pwr_en == 1'b0, "R11 entry with pin low", pwr_en, 0);
        count_to_pwr(k);
        check(k >= 62 && k <= 66, "R11 filter restarts at entry", k, 64);
        wake_n = 1'b1;
        count_to_release(k);
    endtask

    task automatic t_tick_rate();
        int k;
        guarded_wr(A_HOLD, 32'h20);
        tick_div = 4;
        alarm_cycle("R10", k);
        check(k >= 125 && k <= 133, "R10 hold counted in ticks", k, 129);
        tick_div = 1;
    endtask

    task automatic t_hold_fields();
        int k;
        guarded_wr(A_HOLD, 32'h27);
        alarm_cycle("R8", k);
        check(k == 33, "R8 low bits dropped", k, 33);
        guarded_wr(A_HOLD, 32'hFFFF);
        alarm_cycle("R8", k);
        check(k == 4064 + 1, "R8 saturated hold", k, 4065);
    endtask

    task automatic t_filt_saturate();
        int k;
        guarded_wr(A_HOLD, 32'h20);
        guarded_wr(A_FILT, 32'h0001_0000);
        guarded_wr(A_HIB, 32'h1);
        wake_n = 1'b0;
        count_to_pwr(k);
        check(k == 65504 + 3, "R4 saturated filter", k, 65507);
        wake_n = 1'b1;
        count_to_release(k);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_guard();
        t_filter();
        t_alarm();
        t_hib_in_powerup();
        t_pin_in_run();
        t_tick_rate();
        t_hold_fields();
        t_filt_saturate();
        done = 1'b1;
    end

    initial begin
        wait (done || cyc >= WATCHDOG);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule